// File: doc/BRIEF.md
# Return Address Stack Program Counter Sequencer

This block produces the fetch address of a small RISC core that completes one instruction per clock. It holds the current fetch address and a parameterised hardware stack of return addresses below it. Each cycle it takes a decoded control operation and computes the next fetch address. The target address comes from a 16-bit immediate or from the index register. The operations are plain sequencing, jump, conditional jump, call, return, return from interrupt, a fast call/return pair that keeps its return address in the index register and leaves the stack untouched, and push/pop moves between the index register and the stack.

A call pushes the whole stack down by one level. A return pulls it up by one level. Once the stack is full, further entries push the oldest one out. A return fills the freed bottom level with zero. A halt input freezes all state. A synchronous reset clears the fetch address and the stack.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (rst=1 at a rising edge) sets pc0 to 0 and clears every stack level to 0. Reset takes priority over halt. A return executed right after reset loads 0.
- R2: With op=0 (sequential), or with any unused code 10 to 15, pc0 advances by one each cycle and wraps modulo 2^16.
- R3: The target is ix_in when use_ix=1 and imm_addr when use_ix=0. op=1 (jump) always loads the target. op=2 (conditional jump) loads the target when cond=1 and otherwise advances pc0 by one.
- R4: op=3 (call) moves every stack level one deeper, writes pc0+1 into the top level and loads pc0 with the target. The deepest level's old content is lost.
- R5: op=5 (return) loads pc0 with the top stack level and moves every level one up. Zero enters the deepest level.
- R6: op=4 (fast call) presents pc0+1 on ix_wr_data with ix_we=1 in the same cycle and loads pc0 with the target. The stack is not changed.
- R7: op=6 (fast return) loads pc0 from ix_in. The stack is not changed.
- R8: op=7 (return from interrupt) acts as a return and raises gie_set for that cycle only.
- R9: op=8 (push) moves the stack one deeper, writes ix_in into the top level and advances pc0 by one.
- R10: op=9 (pop) presents the top stack level on ix_wr_data with ix_we=1, moves the stack one up and advances pc0 by one.
- R11: With halt=1, pc0 and the stack hold their values, and ix_we and gie_set stay 0.
- R12: ix_we is 1 only for fast call and pop. gie_set is 1 only for return from interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freeze all state and suppress strobes |
| op | input | 4 | Decoded control operation |
| use_ix | input | 1 | Take jump/call target from ix_in instead of imm_addr |
| cond | input | 1 | Condition result for conditional jump |
| imm_addr | input | 16 | Immediate target address |
| ix_in | input | 16 | Current index register value |
| pc0 | output | 16 | Current fetch address |
| ix_we | output | 1 | Index register write strobe |
| ix_wr_data | output | 16 | Index register write-back value |
| gie_set | output | 1 | Global interrupt enable set pulse |

## Verification
A wrong stack level cannot be seen when it is written. It shows up only when a later return, return from interrupt or pop brings it to pc0 or ix_wr_data. For a level k deep, that can be k unwinding operations later. Faults in the fetch path show up at once: a bad jump, increment or halt handling gives a wrong pc0 on the very next cycle. A misdecoded strobe is wrong in the same cycle as the operation. The random mix therefore keeps call depth changing both ways and drives the stack past its depth, so that lost and zero-filled levels are read back.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic [3:0]    op,
  input  logic          use_ix,
  input  logic          cond,
  input  logic [AW-1:0] imm_addr,
  input  logic [AW-1:0] ix_in,
  output logic [AW-1:0] pc0,
  output logic          ix_we,
  output logic [AW-1:0] ix_wr_data,
  output logic          gie_set
);
  localparam logic [3:0] OP_JUMP  = 4'd1;
  localparam logic [3:0] OP_JCC   = 4'd2;
  localparam logic [3:0] OP_CALL  = 4'd3;
  localparam logic [3:0] OP_FCALL = 4'd4;
  localparam logic [3:0] OP_RET   = 4'd5;
  localparam logic [3:0] OP_FRET  = 4'd6;
  localparam logic [3:0] OP_RETI  = 4'd7;
  localparam logic [3:0] OP_PUSH  = 4'd8;
  localparam logic [3:0] OP_POP   = 4'd9;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] stk [1:DEPTH];
  logic [AW-1:0] pc_nxt, top_in;
  logic          sh_dn, sh_up;

  wire [AW-1:0] pc_inc = pc_q + AW'(1);
  wire [AW-1:0] tgt    = use_ix ? ix_in : imm_addr;
  wire          run    = !rst && !halt;

  always_comb begin
    pc_nxt = pc_inc;
    top_in = pc_inc;
    sh_dn  = 1'b0;
    sh_up  = 1'b0;
    case (op)
      OP_JUMP:         pc_nxt = tgt;
      OP_JCC:          if (cond) pc_nxt = tgt;
      OP_CALL:         begin pc_nxt = tgt; sh_dn = 1'b1; end
      OP_FCALL:        pc_nxt = tgt;
      OP_RET, OP_RETI: begin pc_nxt = stk[1]; sh_up = 1'b1; end
      OP_FRET:         pc_nxt = ix_in;
      OP_PUSH:         begin top_in = ix_in; sh_dn = 1'b1; end
      OP_POP:          sh_up = 1'b1;
      default:         ;
    endcase
  end

  always_ff @(posedge clk)
    if (rst)       pc_q <= '0;
    else if (!halt) pc_q <= pc_nxt;

  for (genvar g = 1; g <= DEPTH; g++) begin : lvl
    logic [AW-1:0] above, below;
    if (g == 1) begin : g_top
      assign above = top_in;
    end else begin : g_mid
      assign above = stk[g-1];
    end
    if (g == DEPTH) begin : g_bot
      assign below = '0;
    end else begin : g_up
      assign below = stk[g+1];
    end
    always_ff @(posedge clk)
      if (rst)                 stk[g] <= '0;
      else if (!halt && sh_dn) stk[g] <= above;
      else if (!halt && sh_up) stk[g] <= below;
  end

  assign pc0        = pc_q;
  assign ix_we      = run && (op == OP_FCALL || op == OP_POP);
  assign ix_wr_data = (op == OP_POP) ? stk[1] : pc_inc;
  assign gie_set    = run && (op == OP_RETI);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pc0 == '0 && stk[1] == '0 && stk[DEPTH] == '0));

  assert_halt_freezes_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(pc0) && $stable(stk[1]) && $stable(stk[DEPTH])));

  assert_call_saves_R4: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == OP_CALL) |=> (stk[1] == $past(pc0) + AW'(1) && stk[2] == $past(stk[1])));

  assert_return_loads_R5: assert property (@(posedge clk) disable iff (rst)
    (!halt && (op == OP_RET || op == OP_RETI)) |=> (pc0 == $past(stk[1]) && stk[DEPTH] == '0));

  assert_fret_keeps_stack_R7: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == OP_FRET) |=> (pc0 == $past(ix_in) && $stable(stk[1])));

  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(ix_we && gie_set));
endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  localparam int D = 8;
  logic clk = 0, rst = 1, halt = 0, use_ix = 0, cond = 0;
  logic [3:0] op = 0;
  logic [15:0] imm_addr = 0, ix_in = 0;
  logic [15:0] pc0, ix_wr_data;
  logic ix_we, gie_set;
  int n_chk = 0, n_bad = 0;
  logic [15:0] m_pc;
  logic [15:0] m_stk [1:D];
  string last_req = "R1";

  pc_sequencer uut (.clk(clk), .rst(rst), .halt(halt), .op(op), .use_ix(use_ix),
    .cond(cond), .imm_addr(imm_addr), .ix_in(ix_in), .pc0(pc0), .ix_we(ix_we),
    .ix_wr_data(ix_wr_data), .gie_set(gie_set));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input logic [3:0] o, input logic h);
    if (h) return "R11";
    case (o)
      1, 2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R5";
      6: return "R7";
      7: return "R8";
      8: return "R9";
      9: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] tgt_of();
    return use_ix ? ix_in : imm_addr;
  endfunction

  task automatic model_step();
    logic [15:0] inc = m_pc + 16'd1;
    if (halt) return;
    case (op)
      1: m_pc = tgt_of();
      2: m_pc = cond ? tgt_of() : inc;
      3, 8: begin
        for (int i = D; i > 1; i--) m_stk[i] = m_stk[i-1];
        m_stk[1] = (op == 3) ? inc : ix_in;
        m_pc = (op == 3) ? tgt_of() : inc;
      end
      4: m_pc = tgt_of();
      5, 7, 9: begin
        m_pc = (op == 9) ? inc : m_stk[1];
        for (int i = 1; i < D; i++) m_stk[i] = m_stk[i+1];
        m_stk[D] = 16'd0;
      end
      6: m_pc = ix_in;
      default: m_pc = inc;
    endcase
  endtask

  // called at a negedge: check pc0 from last step, apply inputs, check strobes, advance
  task automatic cyc(input logic [3:0] o, input logic h, input logic ux, input logic c,
                     input logic [15:0] im, input logic [15:0] ix);
    bit exp_we, exp_gie;
    logic [15:0] exp_wd;
    chk(pc0 === m_pc, last_req, pc0, m_pc);
    op = o; halt = h; use_ix = ux; cond = c; imm_addr = im; ix_in = ix;
    #2;
    exp_we  = !h && (o == 4 || o == 9);
    exp_gie = !h && (o == 7);
    exp_wd  = (o == 9) ? m_stk[1] : m_pc + 16'd1;
    chk(ix_we === exp_we, (o == 4) ? "R6" : (o == 9) ? "R10" : h ? "R11" : "R12", {15'd0, ix_we}, {15'd0, exp_we});
    chk(gie_set === exp_gie, (o == 7) ? "R8" : h ? "R11" : "R12", {15'd0, gie_set}, {15'd0, exp_gie});
    if (exp_we) chk(ix_wr_data === exp_wd, (o == 9) ? "R10" : "R6", ix_wr_data, exp_wd);
    model_step();
    last_req = req_of(o, h);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; halt = 1; op = 0;
    repeat (2) @(negedge clk);
    rst = 0; halt = 0;
    m_pc = 0;
    for (int i = 1; i <= D; i++) m_stk[i] = 0;
    last_req = "R1";
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    do_reset();
    // R1: return right after reset loads zero
    cyc(5, 0, 0, 0, 16'h0, 16'h0);
    // R2: wrap at top of address space
    cyc(1, 0, 0, 0, 16'hFFFE, 16'h0);
    cyc(0, 0, 0, 0, 16'h0, 16'h0);
    cyc(12, 0, 0, 0, 16'h0, 16'h0);
    // R3: conditional not taken / taken, ix target
    cyc(2, 0, 0, 0, 16'h1234, 16'h0);
    cyc(2, 0, 1, 1, 16'h1234, 16'hBEEF);
    // R4/R5: overflow past depth, then unwind into zero fill
    for (int k = 0; k < D + 2; k++) cyc(3, 0, 0, 0, 16'h0100 * 16'(k + 1), 16'h0);
    for (int k = 0; k < D + 3; k++) cyc((k % 3 == 0) ? 4'd7 : 4'd5, 0, 0, 0, 16'h0, 16'h0);
    // R9/R10: push then pop round trip
    cyc(8, 0, 0, 0, 16'h0, 16'hA5A5);
    cyc(11, 1, 0, 0, 16'h0, 16'h0);
    cyc(9, 0, 0, 0, 16'h0, 16'h0);
    // R6/R7: fast pair leaves the stack alone
    cyc(3, 0, 0, 0, 16'h4000, 16'h0);
    cyc(4, 0, 0, 0, 16'h5000, 16'h0);
    cyc(6, 0, 0, 0, 16'h0, 16'h4001);
    cyc(5, 0, 0, 0, 16'h0, 16'h0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] o = 4'($urandom_range(0, 15));
      logic h = ($urandom_range(0, 7) == 0);
      if (n == 2000) do_reset();
      cyc(o, h, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end
    // R1: reset while halted still clears
    halt = 1; rst = 1; @(negedge clk); rst = 0; halt = 0;
    m_pc = 0; for (int i = 1; i <= D; i++) m_stk[i] = 0; last_req = "R1";
    cyc(7, 0, 0, 0, 16'h0, 16'h0);
    chk(pc0 === 16'h0, "R1", pc0, 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule